// File: doc/BRIEF.md
# Modem Status Register with Change Detection

This block holds the modem status byte of a serial port. It watches four active-low handshake pins: clear-to-send, data-set-ready, ring and carrier detect. Each pin passes through a two-flop synchronizer. The register presents the asserted level of every line in the upper nibble. In the lower nibble it keeps sticky change flags, and a processor read of the register clears those flags. Whenever a flag is pending and the enable input is high, the block drives an interrupt request.

A loopback input makes the upper nibble follow four output bits of the neighbouring modem control register instead of the pins. Change detection then runs on those looped values, so software can raise flags and the interrupt without any external wiring. The ring line is special: its flag records only the end of a ring, when the pin returns high.

Top module: `mdm_status_reg`

## Requirements
- R1: Bit 0 sets when the clear-to-send level (bit 4) changes in either direction.
- R2: Bit 1 sets when the data-set-ready level (bit 5) changes in either direction.
- R3: Bit 2 sets only when the ring pin goes from low to high, which is bit 6 falling. The opposite edge leaves bit 2 unchanged.
- R4: Bit 3 sets when the carrier-detect level (bit 7) changes in either direction.
- R5: `irq` is high exactly when `msi_en` is 1 and at least one of bits 0 to 3 is 1. It reacts to `msi_en` without a clock.
- R6: With `loop_en` = 0, bits 4, 5, 6 and 7 equal the inverse of `cts_n`, `dsr_n`, `ri_n` and `dcd_n`.
- R7: With `loop_en` = 1, bits 4, 5, 6 and 7 equal `ctl_rts`, `ctl_dtr`, `ctl_out1` and `ctl_out2` one clock after they are sampled, and the pins have no effect.
- R8: A clock edge with `rd_stb` high clears bits 0 to 3 while leaving bits 4 to 7 unchanged.
- R9: If a flag's set condition occurs at the same edge as a clearing read, that flag is 1 afterwards.
- R10: A pin change is visible in `stat_q` after the third rising clock edge that follows it.
- R11: In loopback, a change of a control bit sets the matching change flag, following the same edge rules as R1 to R4.
- R12: While `rst_n` is low, `stat_q` and `irq` are 0 without a clock. After `rst_n` rises, the block stays in reset for two edges and first updates on the third.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_stb | input | 1 | Register read strobe; clears change flags at this edge |
| loop_en | input | 1 | Loopback select from the control register |
| ctl_rts | input | 1 | Control register request-to-send bit |
| ctl_dtr | input | 1 | Control register terminal-ready bit |
| ctl_out1 | input | 1 | Control register general output 1 |
| ctl_out2 | input | 1 | Control register general output 2 |
| msi_en | input | 1 | Modem status interrupt enable |
| cts_n | input | 1 | Clear-to-send pin, active low |
| dsr_n | input | 1 | Data-set-ready pin, active low |
| ri_n | input | 1 | Ring pin, active low |
| dcd_n | input | 1 | Carrier-detect pin, active low |
| stat_q | output | 8 | Status byte: flags in [3:0], levels in [7:4] |
| irq | output | 1 | Modem status interrupt request |

## Verification
A clearing read and a new line change can land on the same clock edge. When they do, the flag must stay set.

The bench provokes this in loopback, where a control-bit change reaches the detector at the same edge that the read strobe is sampled. It then expects the new flags to survive while the older ones are cleared. It repeats the collision when leaving loopback, where the switch back to the pins is itself the change. It judges the result from `stat_q` and `irq` two edges later.

// File: rtl/mdm_pkg.sv
package mdm_pkg;
  localparam int unsigned LINES = 4;
  localparam int unsigned SYNC_STAGES = 2;
  localparam int unsigned RST_STAGES = 2;
  localparam int unsigned STAT_W = 2 * LINES;
  // Line order inside every nibble: 0 clear-to-send, 1 set-ready, 2 ring, 3 carrier
  localparam logic [LINES-1:0] TRAIL_ONLY = 4'b0100;
endpackage

// File: rtl/mdm_rst_sync.sv
module mdm_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_q_n = chain_q[STAGES-1];
endmodule

// File: rtl/mdm_sync.sv
module mdm_sync #(
  parameter int unsigned W = 4,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg_q [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      logic [W-1:0] stg_d;
      if (s == 0) begin : g_first
        assign stg_d = d;
      end else begin : g_next
        assign stg_d = stg_q[s-1];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q[s] <= RST_VAL;
        else        stg_q[s] <= stg_d;
      end
    end
  endgenerate

  assign q = stg_q[STAGES-1];
endmodule

// File: rtl/mdm_delta.sv
module mdm_delta #(
  parameter int unsigned N = 4,
  parameter logic [N-1:0] TRAIL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic [N-1:0] act,
  output logic [N-1:0] lvl_q,
  output logic [N-1:0] flag_q
);
  logic [N-1:0] set;
  logic [N-1:0] lvl_d;
  logic [N-1:0] flag_d;
  logic         lvl_en;
  logic         flag_en;

  genvar i;
  generate
    for (i = 0; i < N; i++) begin : g_line
      if (TRAIL[i]) begin : g_trail
        // asserted level falling means the pin returned high
        assign set[i] = lvl_q[i] & ~act[i];
      end else begin : g_any
        assign set[i] = lvl_q[i] ^ act[i];
      end
    end
  endgenerate

  always_comb begin
    lvl_d   = act;
    lvl_en  = |(act ^ lvl_q);
    flag_d  = set | (flag_q & ~{N{clr}});
    flag_en = clr | (|set);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q  <= '0;
      flag_q <= '0;
    end else begin
      if (lvl_en)  lvl_q  <= lvl_d;
      if (flag_en) flag_q <= flag_d;
    end
  end
endmodule

// File: rtl/mdm_status_reg.sv
module mdm_status_reg
  import mdm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_stb,
  input  logic              loop_en,
  input  logic              ctl_rts,
  input  logic              ctl_dtr,
  input  logic              ctl_out1,
  input  logic              ctl_out2,
  input  logic              msi_en,
  input  logic              cts_n,
  input  logic              dsr_n,
  input  logic              ri_n,
  input  logic              dcd_n,
  output logic [STAT_W-1:0] stat_q,
  output logic              irq
);
  logic             rst_q_n;
  logic [LINES-1:0] pin_raw_n;
  logic [LINES-1:0] pin_sync_n;
  logic [LINES-1:0] ctl_vec;
  logic [LINES-1:0] act;
  logic [LINES-1:0] lvl_q;
  logic [LINES-1:0] flag_q;

  mdm_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .rst_q_n(rst_q_n)
  );

  assign pin_raw_n = {dcd_n, ri_n, dsr_n, cts_n};
  assign ctl_vec   = {ctl_out2, ctl_out1, ctl_dtr, ctl_rts};

  mdm_sync #(.W(LINES), .STAGES(SYNC_STAGES), .RST_VAL('1)) u_sync (
    .clk  (clk),
    .rst_n(rst_q_n),
    .d    (pin_raw_n),
    .q    (pin_sync_n)
  );

  always_comb begin
    act = loop_en ? ctl_vec : ~pin_sync_n;
  end

  mdm_delta #(.N(LINES), .TRAIL(TRAIL_ONLY)) u_delta (
    .clk   (clk),
    .rst_n (rst_q_n),
    .clr   (rd_stb),
    .act   (act),
    .lvl_q (lvl_q),
    .flag_q(flag_q)
  );

  assign stat_q = {lvl_q, flag_q};
  assign irq    = msi_en & (|flag_q);
endmodule

// File: rtl/mdm_status_chk.sv
module mdm_status_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       rd_stb,
  input logic       loop_en,
  input logic [3:0] ctl,
  input logic       msi_en,
  input logic [7:0] stat_q,
  input logic       irq
);
  logic past_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;
  end

  AST_CTS_DELTA: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok && (stat_q[4] != $past(stat_q[4])) |-> stat_q[0]); // R1
  AST_DSR_DELTA: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok && (stat_q[5] != $past(stat_q[5])) |-> stat_q[1]); // R2
  AST_RING_LEAD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok && $rose(stat_q[6]) |-> !$rose(stat_q[2])); // R3
  AST_DCD_DELTA: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok && (stat_q[7] != $past(stat_q[7])) |-> stat_q[3]); // R4
  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    !msi_en |-> !irq); // R5
  AST_IRQ_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (stat_q[3:0] != 4'b0)); // R5
  AST_LOOP_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok && loop_en && $past(loop_en) |-> stat_q[7:4] == $past(ctl)); // R7
  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok && rd_stb && loop_en && $past(loop_en) && (ctl == $past(ctl))
    |=> stat_q[3:0] == 4'b0); // R8
endmodule

bind mdm_status_reg mdm_status_chk u_chk (
  .clk    (clk),
  .rst_n  (rst_q_n),
  .rd_stb (rd_stb),
  .loop_en(loop_en),
  .ctl    ({ctl_out2, ctl_out1, ctl_dtr, ctl_rts}),
  .msi_en (msi_en),
  .stat_q (stat_q),
  .irq    (irq)
);

// File: tb/mdm_status_reg_tb.sv
`timescale 1ns/1ps
module mdm_status_reg_tb;
  logic       clk;
  logic       rst_n;
  logic       rd_stb;
  logic       loop_en;
  logic [3:0] ctl;
  logic [3:0] pin_n;
  logic       msi_en;
  logic [7:0] stat_q;
  logic       irq;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  mdm_status_reg u_dut (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_stb  (rd_stb),
    .loop_en (loop_en),
    .ctl_rts (ctl[0]),
    .ctl_dtr (ctl[1]),
    .ctl_out1(ctl[2]),
    .ctl_out2(ctl[3]),
    .msi_en  (msi_en),
    .cts_n   (pin_n[0]),
    .dsr_n   (pin_n[1]),
    .ri_n    (pin_n[2]),
    .dcd_n   (pin_n[3]),
    .stat_q  (stat_q),
    .irq     (irq)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // {loop, ctl[3:0], pin_n[3:0] as {dcd,ri,dsr,cts}, rd, exp_stat, exp_irq}
  localparam int NV = 13;
  localparam logic [18:0] VEC [NV] = '{
    {1'b0, 4'b0000, 4'b1110, 1'b0, 8'h11, 1'b1},
    {1'b0, 4'b0000, 4'b1110, 1'b1, 8'h10, 1'b0},
    {1'b0, 4'b0000, 4'b1010, 1'b0, 8'h50, 1'b0},
    {1'b0, 4'b0000, 4'b1110, 1'b0, 8'h14, 1'b1},
    {1'b0, 4'b0000, 4'b0110, 1'b1, 8'h98, 1'b1},
    {1'b0, 4'b0000, 4'b1111, 1'b1, 8'h09, 1'b1},
    {1'b0, 4'b0000, 4'b1111, 1'b1, 8'h00, 1'b0},
    {1'b1, 4'b0000, 4'b1111, 1'b0, 8'h00, 1'b0},
    {1'b1, 4'b0011, 4'b1111, 1'b0, 8'h33, 1'b1},
    {1'b1, 4'b0011, 4'b0000, 1'b1, 8'h30, 1'b0},
    {1'b1, 4'b1100, 4'b0000, 1'b1, 8'hCB, 1'b1},
    {1'b0, 4'b1100, 4'b0000, 1'b1, 8'hF3, 1'b1},
    {1'b0, 4'b1100, 4'b0000, 1'b1, 8'hF0, 1'b0}
  };

  function automatic string vec_tag(int i);
    case (i)
      0:  return "R1 R6 R10 cts asserts";
      1:  return "R8 read clears";
      2:  return "R3 ring leading edge ignored";
      3:  return "R3 ring trailing edge";
      4:  return "R4 R8 read then dcd change";
      5:  return "R1 R4 R8 pins release";
      6:  return "R8 clear all";
      7:  return "R7 enter loopback quiet";
      8:  return "R11 R2 R7 loop sets flags";
      9:  return "R7 R8 pins ignored in loop";
      10: return "R9 R11 R3 read collides with change";
      11: return "R9 R6 leave loop with read";
      default: return "R8 R5 final clear";
    endcase
  endfunction

  task automatic chk8(string tag, logic [7:0] act_v, logic [7:0] exp_v);
    checks++;
    if (act_v !== exp_v) begin
      errors++;
      $display("FAIL %s: stat_q=%h expected %h", tag, act_v, exp_v);
    end
  endtask

  task automatic chk1(string tag, logic act_v, logic exp_v);
    checks++;
    if (act_v !== exp_v) begin
      errors++;
      $display("FAIL %s: irq=%b expected %b", tag, act_v, exp_v);
    end
  endtask

  initial begin
    rst_n = 1'b0; rd_stb = 1'b0; loop_en = 1'b0; ctl = '0;
    pin_n = 4'b1111; msi_en = 1'b1;
    repeat (3) @(negedge clk);
    chk8("R12 reset stat", stat_q, 8'h00);
    chk1("R12 reset irq", irq, 1'b0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk8("R12 idle after reset", stat_q, 8'h00);

    for (int i = 0; i < NV; i++) begin
      loop_en = VEC[i][18];
      ctl     = VEC[i][17:14];
      pin_n   = VEC[i][13:10];
      rd_stb  = VEC[i][9];
      @(negedge clk);
      rd_stb = 1'b0;
      @(negedge clk);
      @(negedge clk);
      chk8(vec_tag(i), stat_q, VEC[i][8:1]);
      chk1(vec_tag(i), irq, VEC[i][0]);
    end

    // R10: pin change must not show before the third edge
    msi_en = 1'b0;
    pin_n = 4'b1111;
    @(negedge clk);
    @(negedge clk);
    chk8("R10 not yet after two edges", stat_q, 8'hF0);
    @(negedge clk);
    chk8("R10 R3 R5 flags after third edge", stat_q, 8'h0F);
    chk1("R5 masked irq", irq, 1'b0);
    #1 msi_en = 1'b1;
    #0.5;
    chk1("R5 unmasked irq", irq, 1'b1);

    // R12: async assert, two-edge synchronized release
    @(negedge clk);
    #1 rst_n = 1'b0;
    #0.5;
    chk8("R12 async reset stat", stat_q, 8'h00);
    chk1("R12 async reset irq", irq, 1'b0);
    loop_en = 1'b1; ctl = 4'b1111;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk8("R12 held two edges", stat_q, 8'h00);
    @(negedge clk);
    chk8("R12 R11 first update", stat_q, 8'hFB);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: done=0 expected 1");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule